// File: doc/BRIEF.md
# BCH8 Error Location Bit Corrector

This block repairs one 512-byte data chunk held in a local byte RAM, using error locations that an upstream BCH syndrome engine has already produced. After a one-cycle `start`, it captures a status word and three ECC words. From the status word it takes the reported error count. From the four words together it takes eight packed 13-bit bit locations. It then flips each addressed data bit with a read-modify-write on the RAM and reports how many bits it changed.

A count above eight normally means the chunk cannot be corrected. A freshly erased page also produces such a count, because its stored check bytes read back as all ones. In this case the block counts zero bits, first in the 13 stored check bytes and then in the data bytes. If the total is small, it treats the chunk as blank: it writes 0xFF over the data and returns the number of data zero bits it found. Otherwise it raises the uncorrectable flag.

The RAM has a single port and a one-cycle read latency. Data bytes sit at addresses 0..511 and the stored check bytes at 512..524. Results appear with a one-cycle `done` pulse.

Top module: `errloc_corrector`

## Requirements
- R1: After reset, `done`, `busy`, `uncorrectable`, `ramRdEn` and `ramWrEn` are low and `result` is 0.
- R2: The error count is bits 13:10 of `statusWord`, and all other status bits outside 23:16 have no effect. A count of 0 ends with `result` 0, no flag, and no RAM write.
- R3: The eight locations are packed LSB-first into the 104-bit value {statusWord[23:16], eccWord2, eccWord1, eccWord0}. Location i occupies bits 13i+12..13i.
- R4: Each packed location is XORed with 3 (its two low bits inverted) before use.
- R5: A decoded location k below 4096 inverts bit k%8 of RAM byte k/8. Each such flip adds one to `result`.
- R6: A decoded location of 4096 or more is skipped. It changes no byte, is not counted, and processing continues with the next location.
- R7: Only locations 0..count-1 are used, and they are used in index order. A location that repeats flips its bit back, and both flips are counted.
- R8: When the count is 9..15, zero bits are counted in bytes 512..524 and in data bytes 0..511. If the total is at most 8, data bytes 0..511 become 0xFF, the check bytes are left unchanged, and `result` equals the data zero-bit count.
- R9: When that total exceeds 8, `uncorrectable` is high, `result` is -1, and the RAM is unchanged.
- R10: `busy` is high from the cycle after an accepted `start` until the `done` cycle. `done` lasts exactly one cycle.
- R11: A `start` seen while `busy` is high, including in the `done` cycle, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request, taken only when idle |
| statusWord | input | 32 | Error count field and top location bits |
| eccWord0 | input | 32 | Packed location bits 31..0 |
| eccWord1 | input | 32 | Packed location bits 63..32 |
| eccWord2 | input | 32 | Packed location bits 95..64 |
| ramAddr | output | 10 | Byte RAM address |
| ramRdEn | output | 1 | RAM read strobe, data returned one cycle later |
| ramWrEn | output | 1 | RAM write strobe |
| ramWrData | output | 8 | RAM write data |
| ramRdData | input | 8 | RAM read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 5 | Signed bit count, -1 when uncorrectable |
| uncorrectable | output | 1 | Chunk could not be repaired, valid with done |

## Verification
Two events can share a cycle. One is a new `start` request. The other is the completion of a running job, either its long zero-bit scan or its `done` pulse. The bench drives a second `start` in the middle of an erased-chunk scan, and another in the exact cycle where `done` is high. It then judges that the first job's result and RAM contents are untouched and that no further `done` ever appears. Inside the scan, a byte's read and the zero count of the byte before it also overlap. The erased sweeps judge this by placing zero bits in both regions and checking the threshold at a total of exactly 8 and 9.

// File: rtl/errloc_pkg.sv
package errloc_pkg;

  // which value lands in the result register when a job finishes
  typedef enum logic [1:0] {
    RES_FIX    = 2'd0,
    RES_ERASED = 2'd1,
    RES_BAD    = 2'd2
  } res_sel_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic     capture;
    logic     accEcc;
    logic     accData;
    logic     bumpFix;
    logic     resLoad;
    res_sel_e resSel;
  } dp_ctrl_t;

  function automatic logic [3:0] zeroBits(input logic [7:0] b);
    logic [3:0] n;
    n = '0;
    for (int i = 0; i < 8; i++) n = n + {3'b000, ~b[i]};
    return n;
  endfunction

endpackage

// File: rtl/errloc_datapath.sv
module errloc_datapath
  import errloc_pkg::*;
#(
  parameter int CHUNK_BYTES = 512,
  parameter int MAX_FIX     = 8,
  parameter int LOC_W       = 13,
  parameter int CNT_LSB     = 10,
  parameter int CNT_W       = 4,
  parameter int TAIL_LSB    = 16,
  parameter int IDX_W       = 4,
  parameter int ZC_W        = 4,
  parameter int RES_W       = 5,
  parameter int BYTE_AW     = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dp_ctrl_t                ctl,
  input  logic [31:0]             statusIn,
  input  logic [31:0]             ecc0In,
  input  logic [31:0]             ecc1In,
  input  logic [31:0]             ecc2In,
  input  logic [IDX_W-1:0]        locIdx,
  input  logic [7:0]              ramRdData,
  output logic [CNT_W-1:0]        errCount,
  output logic                    locInRange,
  output logic [BYTE_AW-1:0]      locByte,
  output logic [7:0]              flipData,
  output logic                    overLimit,
  output logic                    dataZeroNone,
  output logic signed [RES_W-1:0] result,
  output logic                    uncorrectable
);

  localparam int NUM_LOCS  = MAX_FIX;
  localparam int PACK_W    = LOC_W * NUM_LOCS;
  localparam int TAIL_W    = PACK_W - 96;
  localparam int SEL_W     = $clog2(NUM_LOCS);
  localparam int BIT_LIMIT = CHUNK_BYTES * 8;
  localparam int ZC_CAP    = MAX_FIX + 1;

  logic [CNT_W-1:0]  countQ;
  logic [TAIL_W-1:0] tailQ;
  logic [31:0]       ecc0Q, ecc1Q, ecc2Q;
  logic [PACK_W-1:0] packedLocs;
  logic [LOC_W-1:0]  locRaw [NUM_LOCS];
  logic [LOC_W-1:0]  selRaw;
  logic [LOC_W-1:0]  decoded;
  logic [2:0]        locBit;
  logic [ZC_W-1:0]   eccZ, dataZ, eccNext, dataNext;
  logic [ZC_W:0]     eccSum, dataSum, totalZ;
  logic [3:0]        byteZeros;
  logic [IDX_W-1:0]  fixCnt;

  assign errCount   = countQ;
  assign packedLocs = {tailQ, ecc2Q, ecc1Q, ecc0Q};

  for (genvar g = 0; g < NUM_LOCS; g++) begin : g_loc
    assign locRaw[g] = packedLocs[g*LOC_W +: LOC_W];
  end

  always_comb begin
    if (32'(locIdx) < NUM_LOCS) selRaw = locRaw[locIdx[SEL_W-1:0]];
    else                        selRaw = '0;
  end

  assign decoded    = selRaw ^ LOC_W'(3);
  assign locInRange = 32'(decoded) < BIT_LIMIT;
  assign locByte    = decoded[3 +: BYTE_AW];
  assign locBit     = decoded[2:0];
  assign flipData   = ramRdData ^ (8'h01 << locBit);

  // zero-bit tallies saturate one above the correction limit
  assign byteZeros = zeroBits(ramRdData);
  assign eccSum    = {1'b0, eccZ} + (ZC_W+1)'(byteZeros);
  assign dataSum   = {1'b0, dataZ} + (ZC_W+1)'(byteZeros);
  assign eccNext   = (32'(eccSum) > ZC_CAP) ? ZC_W'(ZC_CAP) : eccSum[ZC_W-1:0];
  assign dataNext  = (32'(dataSum) > ZC_CAP) ? ZC_W'(ZC_CAP) : dataSum[ZC_W-1:0];
  assign totalZ    = {1'b0, eccZ} + {1'b0, dataZ};
  assign overLimit = 32'(totalZ) > MAX_FIX;
  assign dataZeroNone = (dataZ == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ        <= '0;
      tailQ         <= '0;
      ecc0Q         <= '0;
      ecc1Q         <= '0;
      ecc2Q         <= '0;
      eccZ          <= '0;
      dataZ         <= '0;
      fixCnt        <= '0;
      result        <= '0;
      uncorrectable <= 1'b0;
    end else begin
      if (ctl.capture) begin
        countQ <= statusIn[CNT_LSB +: CNT_W];
        tailQ  <= statusIn[TAIL_LSB +: TAIL_W];
        ecc0Q  <= ecc0In;
        ecc1Q  <= ecc1In;
        ecc2Q  <= ecc2In;
        eccZ   <= '0;
        dataZ  <= '0;
        fixCnt <= '0;
      end
      if (ctl.accEcc)  eccZ   <= eccNext;
      if (ctl.accData) dataZ  <= dataNext;
      if (ctl.bumpFix) fixCnt <= fixCnt + 1'b1;
      if (ctl.resLoad) begin
        uncorrectable <= (ctl.resSel == RES_BAD);
        case (ctl.resSel)
          RES_FIX:    result <= RES_W'(fixCnt);
          RES_ERASED: result <= RES_W'(dataZ);
          default:    result <= '1;
        endcase
      end
    end
  end

  // R7: flips reported never exceed the captured count
  a_r7_fix_within_count: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.resLoad && ctl.resSel == RES_FIX) |-> (32'(fixCnt) <= 32'(countQ)));

  // R8: an erased verdict is only given below the zero-bit limit
  a_r8_erased_under_limit: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.resLoad && ctl.resSel == RES_ERASED) |-> !overLimit);

  // R9: the bad verdict always carries -1
  a_r9_bad_is_minus_one: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.resLoad && ctl.resSel == RES_BAD) |=> (uncorrectable && result == -1));

endmodule

// File: rtl/errloc_ctrl.sv
module errloc_ctrl
  import errloc_pkg::*;
#(
  parameter int CHUNK_BYTES = 512,
  parameter int ECC_BYTES   = 13,
  parameter int MAX_FIX     = 8,
  parameter int CNT_W       = 4,
  parameter int IDX_W       = 4,
  parameter int AW          = 10,
  parameter int BYTE_AW     = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [CNT_W-1:0]   errCount,
  input  logic               locInRange,
  input  logic [BYTE_AW-1:0] locByte,
  input  logic [7:0]         flipData,
  input  logic               overLimit,
  input  logic               dataZeroNone,
  output dp_ctrl_t           ctl,
  output logic [IDX_W-1:0]   locIdx,
  output logic [AW-1:0]      ramAddr,
  output logic               ramRdEn,
  output logic               ramWrEn,
  output logic [7:0]         ramWrData,
  output logic               busy,
  output logic               done
);

  localparam int TOTAL  = CHUNK_BYTES + ECC_BYTES;
  localparam int SCAN_W = $clog2(TOTAL + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_DISPATCH, S_LOC_CHECK, S_LOC_WRITE,
    S_SCAN, S_DRAIN, S_DECIDE, S_FILL, S_DONE
  } state_e;

  state_e             state, stateNext;
  logic [SCAN_W-1:0]  scanIdx;
  logic [BYTE_AW-1:0] fillIdx;
  logic               pendEcc, pendData;
  logic               scanIssue, scanInEcc;
  logic [AW-1:0]      scanAddr;

  assign scanInEcc = 32'(scanIdx) < ECC_BYTES;
  assign scanAddr  = scanInEcc ? AW'(CHUNK_BYTES + 32'(scanIdx))
                               : AW'(32'(scanIdx) - ECC_BYTES);
  assign scanIssue = (state == S_SCAN) && !overLimit && (32'(scanIdx) < TOTAL);

  always_comb begin
    stateNext   = state;
    ctl         = '0;
    ctl.resSel  = RES_FIX;
    ctl.accEcc  = pendEcc;
    ctl.accData = pendData;
    ramAddr     = '0;
    ramRdEn     = 1'b0;
    ramWrEn     = 1'b0;
    ramWrData   = '0;
    done        = 1'b0;
    case (state)
      S_IDLE: if (start) begin
        ctl.capture = 1'b1;
        stateNext   = S_DISPATCH;
      end
      S_DISPATCH: stateNext = (32'(errCount) > MAX_FIX) ? S_SCAN : S_LOC_CHECK;
      S_LOC_CHECK: begin
        if (32'(locIdx) == 32'(errCount)) begin
          ctl.resLoad = 1'b1;
          ctl.resSel  = RES_FIX;
          stateNext   = S_DONE;
        end else if (locInRange) begin
          ramRdEn   = 1'b1;
          ramAddr   = AW'(locByte);
          stateNext = S_LOC_WRITE;
        end
      end
      S_LOC_WRITE: begin
        ramWrEn     = 1'b1;
        ramAddr     = AW'(locByte);
        ramWrData   = flipData;
        ctl.bumpFix = 1'b1;
        stateNext   = S_LOC_CHECK;
      end
      S_SCAN: begin
        if (overLimit) stateNext = S_DECIDE;
        else begin
          ramRdEn = scanIssue;
          ramAddr = scanAddr;
          if (32'(scanIdx) >= TOTAL - 1) stateNext = S_DRAIN;
        end
      end
      S_DRAIN: stateNext = S_DECIDE;
      S_DECIDE: begin
        if (overLimit) begin
          ctl.resLoad = 1'b1;
          ctl.resSel  = RES_BAD;
          stateNext   = S_DONE;
        end else if (dataZeroNone) begin
          ctl.resLoad = 1'b1;
          ctl.resSel  = RES_ERASED;
          stateNext   = S_DONE;
        end else begin
          stateNext = S_FILL;
        end
      end
      S_FILL: begin
        ramWrEn   = 1'b1;
        ramAddr   = AW'(fillIdx);
        ramWrData = 8'hFF;
        if (32'(fillIdx) == CHUNK_BYTES - 1) begin
          ctl.resLoad = 1'b1;
          ctl.resSel  = RES_ERASED;
          stateNext   = S_DONE;
        end
      end
      S_DONE: begin
        done      = 1'b1;
        stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      locIdx   <= '0;
      scanIdx  <= '0;
      fillIdx  <= '0;
      pendEcc  <= 1'b0;
      pendData <= 1'b0;
    end else begin
      state    <= stateNext;
      pendEcc  <= scanIssue && scanInEcc;
      pendData <= scanIssue && !scanInEcc;
      if (ctl.capture) begin
        locIdx  <= '0;
        scanIdx <= '0;
        fillIdx <= '0;
      end
      if (state == S_LOC_WRITE ||
          (state == S_LOC_CHECK && !locInRange && 32'(locIdx) != 32'(errCount)))
        locIdx <= locIdx + 1'b1;
      if (scanIssue) scanIdx <= scanIdx + 1'b1;
      if (state == S_FILL) fillIdx <= fillIdx + 1'b1;
    end
  end

  // R10: completion is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R5: the flip write hits the byte read in the cycle before
  a_r5_rmw_same_byte: assert property (@(posedge clk) disable iff (!rstN)
    (ramWrEn && state == S_LOC_WRITE) |-> ($past(ramRdEn) && ramAddr == $past(ramAddr)));

  // R8: every RAM access stays inside the chunk plus its check bytes
  a_r8_addr_in_window: assert property (@(posedge clk) disable iff (!rstN)
    (ramRdEn || ramWrEn) |-> (32'(ramAddr) < TOTAL));

  // R8: the blanking pass never writes a check byte
  a_r8_fill_data_only: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_FILL) |-> (ramWrEn && 32'(ramAddr) < CHUNK_BYTES && ramWrData == 8'hFF));

  // R11: a start while busy does not restart the job
  a_r11_busy_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && state != S_DONE) |=> busy);

endmodule

// File: rtl/errloc_corrector.sv
module errloc_corrector
  import errloc_pkg::*;
#(
  parameter  int CHUNK_BYTES = 512,
  parameter  int ECC_BYTES   = 13,
  parameter  int MAX_FIX     = 8,
  parameter  int LOC_W       = 13,
  localparam int AW          = $clog2(CHUNK_BYTES + ECC_BYTES),
  localparam int IDX_W       = $clog2(MAX_FIX + 1),
  localparam int ZC_W        = $clog2(MAX_FIX + 2),
  localparam int RES_W       = ((IDX_W > ZC_W) ? IDX_W : ZC_W) + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [31:0]             statusWord,
  input  logic [31:0]             eccWord0,
  input  logic [31:0]             eccWord1,
  input  logic [31:0]             eccWord2,
  output logic [AW-1:0]           ramAddr,
  output logic                    ramRdEn,
  output logic                    ramWrEn,
  output logic [7:0]              ramWrData,
  input  logic [7:0]              ramRdData,
  output logic                    busy,
  output logic                    done,
  output logic signed [RES_W-1:0] result,
  output logic                    uncorrectable
);

  localparam int BYTE_AW = $clog2(CHUNK_BYTES);
  localparam int CNT_W   = 4;

  dp_ctrl_t           ctl;
  logic [CNT_W-1:0]   errCount;
  logic [IDX_W-1:0]   locIdx;
  logic               locInRange, overLimit, dataZeroNone;
  logic [BYTE_AW-1:0] locByte;
  logic [7:0]         flipData;

  errloc_ctrl #(
    .CHUNK_BYTES(CHUNK_BYTES), .ECC_BYTES(ECC_BYTES), .MAX_FIX(MAX_FIX),
    .CNT_W(CNT_W), .IDX_W(IDX_W), .AW(AW), .BYTE_AW(BYTE_AW)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .errCount(errCount), .locInRange(locInRange), .locByte(locByte),
    .flipData(flipData), .overLimit(overLimit), .dataZeroNone(dataZeroNone),
    .ctl(ctl), .locIdx(locIdx),
    .ramAddr(ramAddr), .ramRdEn(ramRdEn), .ramWrEn(ramWrEn), .ramWrData(ramWrData),
    .busy(busy), .done(done)
  );

  errloc_datapath #(
    .CHUNK_BYTES(CHUNK_BYTES), .MAX_FIX(MAX_FIX), .LOC_W(LOC_W),
    .CNT_LSB(10), .CNT_W(CNT_W), .TAIL_LSB(16),
    .IDX_W(IDX_W), .ZC_W(ZC_W), .RES_W(RES_W), .BYTE_AW(BYTE_AW)
  ) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .statusIn(statusWord), .ecc0In(eccWord0), .ecc1In(eccWord1), .ecc2In(eccWord2),
    .locIdx(locIdx), .ramRdData(ramRdData),
    .errCount(errCount), .locInRange(locInRange), .locByte(locByte),
    .flipData(flipData), .overLimit(overLimit), .dataZeroNone(dataZeroNone),
    .result(result), .uncorrectable(uncorrectable)
  );

endmodule

// File: tb/test_errloc_corrector.sv
module test_errloc_corrector;
  localparam int CLK_PERIOD = 10;
  localparam int CHUNK = 512;
  localparam int TOTAL = 525;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [31:0] statusWord = '0, eccWord0 = '0, eccWord1 = '0, eccWord2 = '0;
  logic [9:0] ramAddr;
  logic ramRdEn, ramWrEn, busy, done, uncorrectable;
  logic [7:0] ramWrData, ramRdData;
  logic signed [4:0] result;

  logic [7:0] mem [TOTAL];
  logic [7:0] expMem [TOTAL];
  int checks = 0, failures = 0;
  logic [31:0] lcg = 32'h1234_5678;

  errloc_corrector i_errloc_corrector (
    .clk(clk), .rstN(rstN), .start(start), .statusWord(statusWord),
    .eccWord0(eccWord0), .eccWord1(eccWord1), .eccWord2(eccWord2),
    .ramAddr(ramAddr), .ramRdEn(ramRdEn), .ramWrEn(ramWrEn), .ramWrData(ramWrData),
    .ramRdData(ramRdData), .busy(busy), .done(done), .result(result),
    .uncorrectable(uncorrectable)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (ramRdEn) ramRdData <= mem[ramAddr];
    if (ramWrEn) mem[ramAddr] <= ramWrData;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int nextRand();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return int'(lcg[30:16]);
  endfunction

  task automatic packWords(input logic [12:0] raw [8], input int cnt,
                           output logic [31:0] st, e0, e1, e2);
    logic [103:0] p;
    for (int i = 0; i < 8; i++) p[13*i +: 13] = raw[i];
    e0 = p[31:0];
    e1 = p[63:32];
    e2 = p[95:64];
    st = {8'hA5, p[103:96], 2'b11, 4'(cnt), 10'h2B5};
  endtask

  task automatic runOp(input logic [31:0] st, e0, e1, e2, output int res, output bit bad);
    int cyc;
    @(negedge clk);
    statusWord = st; eccWord0 = e0; eccWord1 = e1; eccWord2 = e2;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 6000) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) check(1'b0, "R10 done timeout", cyc, 6000);
    res = int'(result);
    bad = uncorrectable;
  endtask

  task automatic compareMem(input string tag);
    int bad;
    bad = 0;
    for (int i = 0; i < TOTAL; i++) if (mem[i] !== expMem[i]) bad++;
    check(bad == 0, tag, bad, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    check(1'b0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [12:0] raw [8];
    logic [31:0] st, e0, e1, e2;
    int res, expRes, nDone;
    bit bad;

    for (int i = 0; i < TOTAL; i++) begin
      mem[i] = 8'(i * 37 + 5);
      expMem[i] = mem[i];
    end

    repeat (4) @(negedge clk);
    // R1 reset state
    check(!done && !busy && !uncorrectable, "R1 flags idle", int'(done), 0);
    check(result == 0, "R1 result", int'(result), 0);
    check(!ramRdEn && !ramWrEn, "R1 ram quiet", int'(ramWrEn), 0);
    rstN = 1'b1;

    // R2 count zero with junk locations and junk status bits
    for (int j = 0; j < 8; j++) raw[j] = 13'(j * 211 + 7);
    packWords(raw, 0, st, e0, e1, e2);
    runOp(st, e0, e1, e2, res, bad);
    check(res == 0 && !bad, "R2 zero count result", res, 0);
    compareMem("R2 zero count leaves ram");

    // R3 R4 R5 sweep of every in-range location across all slots
    for (int k = 0; k < 4096; k++) begin
      int pos;
      pos = k % 8;
      for (int j = 0; j < 8; j++) begin
        if (j < pos)       raw[j] = 13'(4096 + j * 100 + k % 50) ^ 13'd3;
        else if (j == pos) raw[j] = 13'(k) ^ 13'd3;
        else               raw[j] = 13'((k * 7 + 13) % 4096) ^ 13'd3;
      end
      packWords(raw, pos + 1, st, e0, e1, e2);
      expMem[k / 8][k % 8] = ~expMem[k / 8][k % 8];
      runOp(st, e0, e1, e2, res, bad);
      check(res == 1 && !bad, "R3/R4/R5/R6 single flip count", res, 1);
      compareMem("R3/R4/R5 flipped byte");
    end

    // R6 out-of-range sweep
    for (int d = 4096; d < 8192; d += 37) begin
      for (int j = 0; j < 8; j++) raw[j] = 13'((d + j * 3) % 4096);
      raw[0] = 13'(d) ^ 13'd3;
      packWords(raw, 1, st, e0, e1, e2);
      runOp(st, e0, e1, e2, res, bad);
      check(res == 0 && !bad, "R6 skipped location", res, 0);
    end
    compareMem("R6 ram unchanged");

    // R7 random orders, duplicates and mixed ranges
    for (int t = 0; t < 300; t++) begin
      int cnt, dec, prev;
      cnt = 1 + nextRand() % 8;
      expRes = 0;
      prev = 0;
      for (int j = 0; j < 8; j++) begin
        int r;
        r = nextRand() % 4;
        if (r == 0)                dec = 4096 + nextRand() % 4096;
        else if (r == 1 && j > 0)  dec = prev;
        else                       dec = nextRand() % 4096;
        prev = dec;
        raw[j] = 13'(dec) ^ 13'd3;
        if (j < cnt && dec < 4096) begin
          expMem[dec / 8][dec % 8] = ~expMem[dec / 8][dec % 8];
          expRes++;
        end
      end
      packWords(raw, cnt, st, e0, e1, e2);
      runOp(st, e0, e1, e2, res, bad);
      check(res == expRes && !bad, "R7 ordered flip count", res, expRes);
      compareMem("R7 ram after ordered flips");
    end

    // R8 R9 erased-chunk sweep
    for (int ei = 0; ei < 4; ei++) begin
      int e;
      e = (ei == 0) ? 0 : (ei == 1) ? 3 : (ei == 2) ? 8 : 9;
      for (int d = 0; d < 10; d++) begin
        for (int i = 0; i < TOTAL; i++) mem[i] = 8'hFF;
        for (int i = 0; i < e; i++) mem[CHUNK + ((i * 7 + 1) % 104) / 8][((i * 7 + 1) % 104) % 8] = 1'b0;
        for (int i = 0; i < d; i++) mem[((i * 397 + d * 13) % 4096) / 8][((i * 397 + d * 13) % 4096) % 8] = 1'b0;
        for (int i = 0; i < TOTAL; i++) expMem[i] = mem[i];
        if (e + d <= 8) begin
          for (int i = 0; i < CHUNK; i++) expMem[i] = 8'hFF;
          expRes = d;
        end else begin
          expRes = -1;
        end
        for (int j = 0; j < 8; j++) raw[j] = 13'(nextRand() % 4096);
        packWords(raw, 9 + d % 7, st, e0, e1, e2);
        runOp(st, e0, e1, e2, res, bad);
        if (e + d <= 8) begin
          check(res == expRes && !bad, "R8 erased result", res, expRes);
          compareMem("R8 erased ram");
        end else begin
          check(res == -1 && bad, "R9 uncorrectable result", res, -1);
          compareMem("R9 ram untouched");
        end
      end
    end

    // R10 R11 start while busy and in the done cycle
    for (int i = 0; i < TOTAL; i++) mem[i] = 8'hFF;
    mem[CHUNK + 2][5] = 1'b0;
    mem[40][1] = 1'b0;
    mem[300][6] = 1'b0;
    for (int i = 0; i < TOTAL; i++) expMem[i] = (i < CHUNK) ? 8'hFF : mem[i];
    for (int j = 0; j < 8; j++) raw[j] = 13'(j * 5);
    packWords(raw, 12, st, e0, e1, e2);
    @(negedge clk);
    statusWord = st; eccWord0 = e0; eccWord1 = e1; eccWord2 = e2;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy, "R10 busy after start", int'(busy), 1);
    repeat (20) @(negedge clk);
    packWords(raw, 0, st, e0, e1, e2);
    statusWord = st;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    nDone = 0;
    while (!done && nDone < 6000) begin
      @(negedge clk);
      nDone++;
    end
    check(int'(result) == 2 && !uncorrectable, "R11 first job result kept", int'(result), 2);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    nDone = 0;
    for (int c = 0; c < 20; c++) begin
      if (done) nDone++;
      @(negedge clk);
    end
    check(nDone == 0, "R11 no extra done", nDone, 0);
    check(!busy, "R10 idle after done", int'(busy), 0);
    compareMem("R11 ram of first job");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule